// File: doc/BRIEF.md
# Serial Frame Sync Generator

This block produces the frame synchronization signal for one direction of a synchronous serial port. All of its timing advances on a bit-clock enable, so one bit time is one system clock cycle in which `bit_en` is high. A frame starts in one of two ways. A free-running period counter can start it at a fixed spacing. If the period setting is zero, an external start strobe starts it instead. From each frame start the block shapes the sync pin according to the selected waveform: a short pulse of either polarity, a level that marks the data portion of the frame, or a level that toggles once per frame.

While the sync is active, the block can also carry a short tag word of up to 16 bits. A transmit instance shifts the tag word out most-significant bit first. A receive instance samples the data line into its tag register. Normal data always wins over the tag: the tag stops at the bit time where normal data is due to begin. The block also watches the sync pin for a selected edge and records each one in a sticky flag. Only the clear strobe resets that flag.

Top module: `frame_sync_gen`

## Requirements
- R1: Out of reset, `sync_flag_o`, `sd_oe`, `sd_o` and `rx_tag_o` are 0, and no frame is running. `fs_o` then rests at its idle level: 1 for waveform codes 1 and 3, 0 for all other codes.
- R2: When `cfg_period` is P and P is not 0, a frame starts on every 2*(P+1)-th bit time. `start_i` is ignored in that case. When P is 0, a frame starts only at a bit time in which `start_i` is high.
- R3: Waveform code 2 drives `fs_o` high for `cfg_len`+1 bit times (1 to 256), starting at the frame start. Code 1 drives the inverse of that, so the pin is low for the same bit times and high otherwise.
- R4: Code 4 drives `fs_o` high from `cfg_start_dly` bit times after the frame start until the next frame start. Code 3 drives the inverse. Codes 0, 6 and 7 hold `fs_o` low.
- R5: Code 5 inverts `fs_o` at every frame start, beginning from 0.
- R6: A transmit instance with `cfg_tag_en` = 1 asserts `sd_oe` for min(`cfg_len`+1, 16) bit times from the frame start. During those bit times, `sd_o` carries the low bits of `tag_i`, as captured at the frame start, most-significant bit first. With `cfg_tag_en` = 0, `sd_oe` stays 0.
- R7: Tag bit times at or beyond `cfg_start_dly` are dropped, because normal data takes priority. With `cfg_start_dly` = 0, no tag bit is sent.
- R8: A receive instance clears `rx_tag_o` at each frame start. At each tag bit time (same window as R6 and R7), it shifts `sd_i` into bit 0 of `rx_tag_o`. A receive instance never asserts `sd_oe`.
- R9: `cfg_edge_fall` = 0 selects rising edges of `fs_o`, and 1 selects falling edges. One clock after the selected edge appears on `fs_o`, `sync_flag_o` is 1.
- R10: `sync_flag_o` stays 1 until a cycle with `clr_i` high. If an edge is detected in the same cycle as the clear, the flag stays 1.
- R11: In cycles with `bit_en` low, the frame timing does not advance, and neither `fs_o` nor the tag state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Bit-clock enable; one high cycle is one bit time |
| cfg_wave | input | 3 | Waveform code (0..5, others act as 0) |
| cfg_len | input | LEN_W | Sync length minus one |
| cfg_period | input | PER_W | Period setting; 0 selects strobe-started frames |
| cfg_tag_en | input | 1 | Enables transmit tag output |
| cfg_edge_fall | input | 1 | Edge select for the status flag |
| cfg_start_dly | input | DLY_W | Bit times from frame start to first normal data bit |
| start_i | input | 1 | External frame start strobe |
| clr_i | input | 1 | Clears the sync flag |
| tag_i | input | TAG_W | Transmit sync holding word |
| sd_i | input | 1 | Serial data line sampled by a receive instance |
| fs_o | output | 1 | Frame sync pin |
| sd_o | output | 1 | Transmit tag bit |
| sd_oe | output | 1 | Tag bit valid / drive enable |
| rx_tag_o | output | TAG_W | Received sync holding word |
| sync_flag_o | output | 1 | Sticky edge-detect flag |

## Verification
The bench targets the places where off-by-one errors would hide. One is the pulse length at `cfg_len` = 0 and at 255. A design that counted the length field directly would give a zero-length pulse in the first case, or overflow in the second. Another is the tag window when the start delay is shorter than the tag. A design without the priority rule would keep driving `sd_oe` into the data slot, and a design that truncated wrongly would shift a misaligned word. The bench also runs a full 16-bit tag next to a long sync, where a missing clamp would index past the holding word. It drives `clr_i` high in every cycle, where a design that let the clear win would never show the flag. It sends start strobes while the period counter is running; a design that obeyed them would start frames early. Finally, `bit_en` has gaps, so a design that advanced on raw clocks would drift out of step with the expected stream.

// File: rtl/fsg_pkg.sv
`timescale 1ns/1ps
package fsg_pkg;

  typedef enum logic [2:0] {
    WV_OFF       = 3'd0,
    WV_NEG_PULSE = 3'd1,
    WV_POS_PULSE = 3'd2,
    WV_LOW_DATA  = 3'd3,
    WV_HIGH_DATA = 3'd4,
    WV_TOGGLE    = 3'd5
  } wave_e;

endpackage

// File: rtl/fsg_timer.sv
`timescale 1ns/1ps
module fsg_timer #(
  parameter int PER_W = 8,
  parameter int POS_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic [PER_W-1:0] period_i,
  input  logic             start_i,
  output logic             fire_o,
  output logic             run_o,
  output logic             tog_o,
  output logic [POS_W-1:0] pos_o
);
  localparam int CNT_W = PER_W + 1;
  localparam logic [POS_W-1:0] POS_MAX = '1;

  // last count value of a frame: 2*(p+1)-1
  function automatic logic [CNT_W-1:0] last_tick(input logic [PER_W-1:0] p);
    return {p, 1'b1};
  endfunction

  logic [CNT_W-1:0] per_cnt;
  logic             periodic;
  logic             wrap;

  assign periodic = (period_i != '0);
  assign wrap     = periodic && (per_cnt >= last_tick(period_i));
  assign fire_o   = bit_en && (periodic ? wrap : start_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_cnt <= '0;
    end else if (bit_en) begin
      if (!periodic || wrap) per_cnt <= '0;
      else                   per_cnt <= per_cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_o <= '0;
      run_o <= 1'b0;
      tog_o <= 1'b0;
    end else if (fire_o) begin
      pos_o <= '0;
      run_o <= 1'b1;
      tog_o <= ~tog_o;
    end else if (bit_en && run_o && (pos_o != POS_MAX)) begin
      pos_o <= pos_o + POS_W'(1);
    end
  end

  p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> (run_o && pos_o == '0));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(pos_o) && $stable(tog_o) && $stable(run_o)));

  p_no_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (periodic && !wrap) |=> !(run_o && pos_o == '0 && !$past(fire_o)) || $stable(pos_o));

endmodule

// File: rtl/fsg_wave.sv
`timescale 1ns/1ps
module fsg_wave
  import fsg_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int DLY_W = 8,
  parameter int POS_W = 9
) (
  input  logic [2:0]       wave_i,
  input  logic             run_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic             tog_i,
  output logic             fs_o
);
  function automatic logic level_for(
    input logic [2:0]       w,
    input logic             run,
    input logic [POS_W-1:0] pos,
    input logic [LEN_W-1:0] len,
    input logic [DLY_W-1:0] dly,
    input logic             tog
  );
    logic in_pulse;
    logic in_data;
    in_pulse = run && (pos < POS_W'(len) + POS_W'(1));
    in_data  = run && (pos >= POS_W'(dly));
    case (wave_e'(w))
      WV_NEG_PULSE: return ~in_pulse;
      WV_POS_PULSE: return in_pulse;
      WV_LOW_DATA:  return ~in_data;
      WV_HIGH_DATA: return in_data;
      WV_TOGGLE:    return tog;
      default:      return 1'b0;
    endcase
  endfunction

  assign fs_o = level_for(wave_i, run_i, pos_i, len_i, dly_i, tog_i);

endmodule

// File: rtl/fsg_tag.sv
`timescale 1ns/1ps
module fsg_tag #(
  parameter bit IS_TX = 1'b1,
  parameter int TAG_W = 16,
  parameter int LEN_W = 8,
  parameter int DLY_W = 8,
  parameter int POS_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             fire_i,
  input  logic             run_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic             tag_en_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             sd_i,
  output logic             sd_o,
  output logic             sd_oe,
  output logic [TAG_W-1:0] rx_tag_o
);
  localparam logic [POS_W-1:0] TAG_CAP = POS_W'(TAG_W);
  localparam logic [TAG_W-1:0] BIT0    = TAG_W'(1);

  // number of tag bits in a frame: min(len+1, TAG_W)
  function automatic logic [POS_W-1:0] tag_count(input logic [LEN_W-1:0] len);
    logic [POS_W-1:0] n;
    n = POS_W'(len) + POS_W'(1);
    return (n > TAG_CAP) ? TAG_CAP : n;
  endfunction

  logic [POS_W-1:0] tag_n;
  logic             tag_win;

  assign tag_n   = tag_count(len_i);
  // normal data owns every bit time from the start delay onward
  assign tag_win = run_i && (pos_i < tag_n) && (pos_i < POS_W'(dly_i));

  generate
    if (IS_TX) begin : g_tx
      logic [TAG_W-1:0] hold_q;
      logic [POS_W-1:0] idx;
      logic             unused_rx;

      assign unused_rx = sd_i;
      assign idx       = tag_n - POS_W'(1) - pos_i;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      hold_q <= '0;
        else if (fire_i) hold_q <= tag_i;
      end

      assign sd_oe    = tag_win && tag_en_i;
      assign sd_o     = sd_oe && (((hold_q >> idx) & BIT0) != '0);
      assign rx_tag_o = '0;

      p_tx_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sd_oe |-> (pos_i < TAG_CAP));
      p_tx_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !tag_en_i |-> !sd_oe);
      p_priority_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sd_oe |-> (pos_i < POS_W'(dly_i)));
    end else begin : g_rx
      logic [TAG_W-1:0] shift_q;
      logic             unused_tx;

      assign unused_tx = ^{tag_i, tag_en_i};

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  shift_q <= '0;
        else if (fire_i)             shift_q <= '0;
        else if (bit_en && tag_win)  shift_q <= {shift_q[TAG_W-2:0], sd_i};
      end

      assign sd_oe    = 1'b0;
      assign sd_o     = 1'b0;
      assign rx_tag_o = shift_q;

      p_rx_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i |=> (rx_tag_o == '0));
      p_rx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!fire_i && !tag_win) |=> $stable(rx_tag_o));
    end
  endgenerate

endmodule

// File: rtl/fsg_edge.sv
`timescale 1ns/1ps
module fsg_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic fs_i,
  input  logic fall_sel_i,
  input  logic clr_i,
  output logic hit_o,
  output logic flag_o
);
  logic fs_prev;
  logic primed;

  assign hit_o = primed && (fall_sel_i ? (fs_prev && !fs_i) : (!fs_prev && fs_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_prev <= 1'b0;
      primed  <= 1'b0;
      flag_o  <= 1'b0;
    end else begin
      fs_prev <= fs_i;
      primed  <= 1'b1;
      flag_o  <= hit_o || (flag_o && !clr_i);
    end
  end

  p_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |=> flag_o);
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_i) |=> flag_o);
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !hit_o) |=> !flag_o);
  p_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> $past(hit_o));

endmodule

// File: rtl/frame_sync_gen.sv
`timescale 1ns/1ps
module frame_sync_gen
  import fsg_pkg::*;
#(
  parameter bit IS_TX = 1'b1,
  parameter int PER_W = 8,
  parameter int LEN_W = 8,
  parameter int DLY_W = 8,
  parameter int TAG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic [2:0]       cfg_wave,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic [PER_W-1:0] cfg_period,
  input  logic             cfg_tag_en,
  input  logic             cfg_edge_fall,
  input  logic [DLY_W-1:0] cfg_start_dly,
  input  logic             start_i,
  input  logic             clr_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             sd_i,
  output logic             fs_o,
  output logic             sd_o,
  output logic             sd_oe,
  output logic [TAG_W-1:0] rx_tag_o,
  output logic             sync_flag_o
);
  localparam int POS_W = ((LEN_W > DLY_W) ? LEN_W : DLY_W) + 1;

  logic             fire;
  logic             run;
  logic             tog;
  logic [POS_W-1:0] pos;
  logic             edge_hit;

  fsg_timer #(.PER_W(PER_W), .POS_W(POS_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .period_i(cfg_period),
    .start_i(start_i), .fire_o(fire), .run_o(run), .tog_o(tog), .pos_o(pos)
  );

  fsg_wave #(.LEN_W(LEN_W), .DLY_W(DLY_W), .POS_W(POS_W)) u_wave (
    .wave_i(cfg_wave), .run_i(run), .pos_i(pos), .len_i(cfg_len),
    .dly_i(cfg_start_dly), .tog_i(tog), .fs_o(fs_o)
  );

  fsg_tag #(.IS_TX(IS_TX), .TAG_W(TAG_W), .LEN_W(LEN_W), .DLY_W(DLY_W), .POS_W(POS_W)) u_tag (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fire_i(fire), .run_i(run),
    .pos_i(pos), .len_i(cfg_len), .dly_i(cfg_start_dly), .tag_en_i(cfg_tag_en),
    .tag_i(tag_i), .sd_i(sd_i), .sd_o(sd_o), .sd_oe(sd_oe), .rx_tag_o(rx_tag_o)
  );

  fsg_edge u_edge (
    .clk(clk), .rst_n(rst_n), .fs_i(fs_o), .fall_sel_i(cfg_edge_fall),
    .clr_i(clr_i), .hit_o(edge_hit), .flag_o(sync_flag_o)
  );

  p_pos_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cfg_wave == WV_POS_PULSE) |=> (cfg_wave != WV_POS_PULSE || fs_o));
  p_neg_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cfg_wave == WV_NEG_PULSE) |=> (cfg_wave != WV_NEG_PULSE || !fs_o));
  p_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cfg_wave == WV_TOGGLE) |=> (cfg_wave != WV_TOGGLE || fs_o != $past(fs_o)));
  p_off_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wave == WV_OFF || cfg_wave > WV_TOGGLE) |-> !fs_o);
  p_flag_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit && !clr_i) |=> sync_flag_o);

endmodule

// File: tb/frame_sync_gen_tb.sv
`timescale 1ns/1ps
module frame_sync_gen_tb;
  localparam int PER_W = 8;
  localparam int LEN_W = 8;
  localparam int DLY_W = 8;
  localparam int TAG_W = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst_n = 1'b0;
  logic             bit_en = 1'b0;
  logic [2:0]       cfg_wave = '0;
  logic [LEN_W-1:0] cfg_len = '0;
  logic [PER_W-1:0] cfg_period = '0;
  logic             cfg_tag_en = 1'b0;
  logic             cfg_edge_fall = 1'b0;
  logic [DLY_W-1:0] cfg_start_dly = '0;
  logic             start_i = 1'b0;
  logic             clr_i = 1'b0;
  logic [TAG_W-1:0] tag_i = '0;
  logic             sd_i = 1'b0;

  logic             fs_tx, sd_tx, oe_tx, flag_tx;
  logic [TAG_W-1:0] rxt_tx;
  logic             fs_rx, sd_rx, oe_rx, flag_rx;
  logic [TAG_W-1:0] rxt_rx;

  frame_sync_gen #(.IS_TX(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .cfg_wave(cfg_wave), .cfg_len(cfg_len),
    .cfg_period(cfg_period), .cfg_tag_en(cfg_tag_en), .cfg_edge_fall(cfg_edge_fall),
    .cfg_start_dly(cfg_start_dly), .start_i(start_i), .clr_i(clr_i), .tag_i(tag_i),
    .sd_i(sd_i), .fs_o(fs_tx), .sd_o(sd_tx), .sd_oe(oe_tx), .rx_tag_o(rxt_tx),
    .sync_flag_o(flag_tx)
  );

  frame_sync_gen #(.IS_TX(1'b0)) u_dut_rx (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .cfg_wave(cfg_wave), .cfg_len(cfg_len),
    .cfg_period(cfg_period), .cfg_tag_en(cfg_tag_en), .cfg_edge_fall(cfg_edge_fall),
    .cfg_start_dly(cfg_start_dly), .start_i(start_i), .clr_i(clr_i), .tag_i(tag_i),
    .sd_i(sd_i), .fs_o(fs_rx), .sd_o(sd_rx), .sd_oe(oe_rx), .rx_tag_o(rxt_rx),
    .sync_flag_o(flag_rx)
  );

  typedef struct {
    logic        fs;
    logic        oe;
    logic        sd;
    logic        flag;
    logic [15:0] rxt;
    string       req;
  } item_t;

  item_t q[$];
  item_t it;
  int n_cmp = 0;
  int n_bad = 0;

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  // monitor: compares one expected item per clock, after the edge settles
  always @(posedge clk) begin
    #1;
    if (q.size() != 0) begin
      it = q.pop_front();
      check(it.req, "tx fs_o",        16'(fs_tx),   16'(it.fs));
      check(it.req, "rx fs_o",        16'(fs_rx),   16'(it.fs));
      check(it.req, "tx sd_oe",       16'(oe_tx),   16'(it.oe));
      check(it.req, "tx sd_o",        16'(sd_tx),   16'(it.sd));
      check(it.req, "tx sync_flag_o", 16'(flag_tx), 16'(it.flag));
      check(it.req, "rx sync_flag_o", 16'(flag_rx), 16'(it.flag));
      check(it.req, "rx rx_tag_o",    rxt_rx,       it.rxt);
      check(it.req, "rx sd_oe R8",    16'(oe_rx),   16'h0);
      check(it.req, "tx rx_tag_o",    rxt_tx,       16'h0);
    end
  end

  // requirement-level model state
  int          m_cnt, m_pos;
  bit          m_run, m_tog, m_flag, m_primed, m_prev;
  logic [15:0] m_hold, m_sh;
  int          cw, cl, cp, cd;
  bit          ct, ce;
  logic [15:0] lf = 16'hACE1;

  function automatic bit exp_fs();
    bit pulse = m_run && (m_pos <= cl);
    bit data  = m_run && (m_pos >= cd);
    case (cw)
      1: return !pulse;
      2: return pulse;
      3: return !data;
      4: return data;
      5: return m_tog;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int tag_bits();
    return (cl + 1 > 16) ? 16 : cl + 1;
  endfunction

  function automatic bit in_tag();
    return m_run && (m_pos < tag_bits()) && (m_pos < cd);
  endfunction

  task automatic run_test(input int w, input int len, input int per, input bit ten,
                          input bit efall, input int dly, input int ncyc,
                          input string req, input int clr_mode);
    item_t e;
    bit fs_now, hit, win, fire;
    @(negedge clk);
    rst_n = 1'b0; bit_en = 1'b0; start_i = 1'b0; clr_i = 1'b0;
    cfg_wave = 3'(w); cfg_len = LEN_W'(len); cfg_period = PER_W'(per);
    cfg_tag_en = ten; cfg_edge_fall = efall; cfg_start_dly = DLY_W'(dly);
    cw = w; cl = len; cp = per; ct = ten; ce = efall; cd = dly;
    @(negedge clk);
    rst_n = 1'b1;
    m_cnt = 0; m_pos = 0; m_run = 0; m_tog = 0; m_flag = 0; m_primed = 0; m_prev = 0;
    m_hold = '0; m_sh = '0;
    for (int c = 0; c < ncyc; c++) begin
      bit_en  = (c % 3 != 2);
      start_i = (per == 0) ? (c % 23 == 5) : (c % 7 == 0);
      clr_i   = (clr_mode == 1) ? 1'b1 : (clr_mode == 2) ? (c % 11 == 0) : (c % 29 == 0);
      lf      = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      tag_i   = lf;
      sd_i    = lf[3];
      // flag follows the fs level seen in this cycle
      fs_now   = exp_fs();
      win      = in_tag();
      hit      = m_primed && (ce ? (m_prev && !fs_now) : (!m_prev && fs_now));
      m_flag   = hit || (m_flag && !clr_i);
      m_prev   = fs_now;
      m_primed = 1'b1;
      if (bit_en) begin
        fire = (cp != 0) ? (m_cnt >= 2 * cp + 1) : start_i;
        if (cp == 0 || m_cnt >= 2 * cp + 1) m_cnt = 0;
        else m_cnt++;
        if (fire) begin
          m_pos = 0; m_run = 1; m_tog = !m_tog; m_hold = tag_i; m_sh = '0;
        end else begin
          if (win) m_sh = {m_sh[14:0], sd_i};
          if (m_run && m_pos < 511) m_pos++;
        end
      end
      e.fs   = exp_fs();
      e.oe   = in_tag() && ct;
      e.sd   = e.oe ? m_hold[tag_bits() - 1 - m_pos] : 1'b0;
      e.flag = m_flag;
      e.rxt  = m_sh;
      e.req  = (c == 0) ? "R1 reset state" : req;
      q.push_back(e);
      @(negedge clk);
    end
  endtask

  bit done = 1'b0;

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    run_test(2,   2,   3, 1, 0,  20,  120, "R2 R3 R6 R9 periodic pos pulse", 0);
    run_test(1,   0,   1, 1, 1,   4,  100, "R3 R9 R11 neg pulse len1 falling", 0);
    run_test(4,   5,   4, 0, 0,   3,  120, "R4 R6 high in data, tag off", 0);
    run_test(3,   5,   4, 1, 1,   3,  120, "R4 R7 low in data", 0);
    run_test(0,   3,   2, 1, 0,   9,   60, "R4 code0 low", 0);
    run_test(7,   3,   2, 1, 0,   9,   60, "R4 code7 low", 0);
    run_test(5,   1,   2, 1, 1,   9,  100, "R5 R9 toggle", 0);
    run_test(2,  15,  15, 1, 0,   5,  200, "R7 R8 tag cut by delay", 0);
    run_test(2,   4,   3, 1, 0,   0,   80, "R7 zero delay no tag", 0);
    run_test(2, 255, 200, 1, 0, 220, 1300, "R3 R6 len 256", 0);
    run_test(2,   7,   0, 1, 0,  12,  200, "R2 R8 strobe start", 0);
    run_test(2,  20,  10, 1, 0,  30,  120, "R6 R8 full 16-bit tag", 0);
    run_test(5,   0,   1, 1, 0,   2,  100, "R10 clear every cycle", 1);
    run_test(2,   1,   2, 1, 0,   3,  100, "R10 sparse clear", 2);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule